// File: doc/BRIEF.md
# Boost-Rest Heating Access Controller

This block decides which modules of a die receive a high-activity heating stimulus during a thermally driven burn-in, so that a set of thermal nodes reaches and then holds a target temperature map. Each node has its own sampled temperature, a low and a high limit, a heating-trigger level set between them, and a stop-boost level. Each node also has a don't-care flag, a priority weight and the index of the module that heats it. Temperatures arrive as unsigned samples together with a one-cycle valid strobe. All decisions are taken on that strobe, and the module enables are registered.

After reset the block is in boost mode. In this mode every specified node that has not yet reached its stop-boost level asks for full heating. It is never boosted again once it has reached that level. When every specified node sits inside its window, the block switches to rest mode and stays there. In rest mode a node asks for heat once it drops below its trigger. It keeps asking until it reaches its high limit, so the gap between trigger and low limit lets it wait for access. Only a limited number of modules may be heated at once. A granted module keeps its slot until its own stop condition is met. Free slots go to the requesting modules with the largest weight. A node at or above a global overheat limit shuts all heating off.

Top module: `therm_boost_rest_ctl`

## Requirements
- R1: While reset is asserted and after it is released, before the first strobe, `heat_en` is all zero and `rest_mode` is 0 (0 = boost, 1 = rest).
- R2: `heat_en` and `rest_mode` change only on the clock edge at which `smp_vld` is high. Temperature changes between strobes have no effect on the outputs.
- R3: In boost mode a node that is not don't-care requests its module while its temperature is below its stop-boost level and it has not reached that level at any earlier boost strobe. Once a strobe sees it at or above its stop-boost level, it never requests in boost mode again.
- R4: On a strobe in boost mode where every node with `dont_care` = 0 satisfies low <= temperature <= high, `rest_mode` becomes 1, and the decisions of that same strobe already follow rest rules. Rest mode lasts until reset. Don't-care nodes are excluded from the window check.
- R5: In rest mode a non-don't-care node starts requesting when its temperature is below its trigger level. It keeps requesting, whether granted or not, until a strobe sees it at or above its high limit.
- R6: In rest mode a module is heated only if every node mapped to it is below its own high limit. In boost mode no such gate applies.
- R7: At most W bits of `heat_en` are set.
- R8: A module's priority is the largest `prio_wt` among its requesting nodes. Free slots go to the eligible modules in decreasing priority, and on equal priority the lower module index wins.
- R9: A module that is enabled keeps its enable on the next strobe as long as it still requests and passes the R6 gate, even if higher-priority modules are waiting.
- R10: On a strobe where any node, don't-care or not, is at or above `hot_lim`, all of `heat_en` goes to 0.
- R11: A node whose `node_mod` value is NMOD or larger belongs to no module and does not influence any module's request, gate or priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Temperature sample valid strobe; decisions are taken on it |
| temp | input | NNODE*TW | Per-node unsigned temperature samples |
| lo_lim | input | NNODE*TW | Per-node low limit |
| hi_lim | input | NNODE*TW | Per-node high limit |
| trig_lvl | input | NNODE*TW | Per-node heating-trigger level (above low limit) |
| stop_lvl | input | NNODE*TW | Per-node stop-boost level |
| hot_lim | input | TW | Global overheat limit |
| dont_care | input | NNODE | Per-node don't-care flag |
| node_mod | input | NNODE*MW | Module index of each node |
| prio_wt | input | NNODE*PW | Per-node unsigned priority weight |
| heat_en | output | NMOD | Module heating enables |
| rest_mode | output | 1 | 0 = boost mode, 1 = rest mode |

## Verification
Both outputs are due exactly one clock edge after a strobe: the edge that sees `smp_vld` high loads them, and they are stable by the following falling edge. The bench raises the strobe for one cycle at a falling edge and compares at the next falling edge. Between strobes it changes temperatures and waits idle cycles, which checks that nothing moves without a strobe. The expected enables and mode come from a bench model that advances its own boost and hysteresis state once per strobe, in the same order as the sampled decisions.

// File: rtl/therm_pkg.sv
package therm_pkg;
  typedef enum logic {
    MODE_BOOST = 1'b0,
    MODE_REST  = 1'b1
  } heat_mode_e;
endpackage

// File: rtl/therm_node_cell.sv
module therm_node_cell #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_vld,
  input  logic          rest_now,
  input  logic [TW-1:0] temp,
  input  logic [TW-1:0] lo_lim,
  input  logic [TW-1:0] hi_lim,
  input  logic [TW-1:0] trig_lvl,
  input  logic [TW-1:0] stop_lvl,
  input  logic [TW-1:0] hot_lim,
  input  logic          dc,
  output logic          req,
  output logic          below_hi,
  output logic          in_win,
  output logic          over_hot
);
  logic boosted_q, boosted_d;
  logic need_q, need_d;
  logic rest_want;

  always_comb begin
    in_win   = (temp >= lo_lim) && (temp <= hi_lim);
    below_hi = (temp < hi_lim);
    over_hot = (temp >= hot_lim);
    // rest hysteresis: set below trigger, clear at high limit
    if (dc)                  rest_want = 1'b0;
    else if (temp < trig_lvl) rest_want = 1'b1;
    else if (temp >= hi_lim)  rest_want = 1'b0;
    else                      rest_want = need_q;
    req = rest_now ? rest_want : (!dc && !boosted_q && (temp < stop_lvl));
  end

  always_comb begin
    boosted_d = boosted_q;
    need_d    = need_q;
    if (!rest_now && (temp >= stop_lvl)) boosted_d = 1'b1;
    if (rest_now) need_d = rest_want;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boosted_q <= 1'b0;
      need_q    <= 1'b0;
    end else if (smp_vld) begin
      boosted_q <= boosted_d;
      need_q    <= need_d;
    end
  end
endmodule

// File: rtl/therm_grant_arb.sv
module therm_grant_arb #(
  parameter int NMOD = 3,
  parameter int W    = 2,
  parameter int PW   = 4
) (
  input  logic [NMOD-1:0]         req,
  input  logic [NMOD-1:0]         gate,
  input  logic [NMOD-1:0][PW-1:0] prio,
  input  logic [NMOD-1:0]         held,
  output logic [NMOD-1:0]         grant
);
  logic [NMOD-1:0] keep;
  int              nkeep;
  int              free;
  int              best;
  logic [PW-1:0]   best_p;
  logic            found;

  always_comb begin
    keep  = held & req & gate;
    nkeep = 0;
    for (int m = 0; m < NMOD; m++) nkeep += int'(keep[m]);
    free   = W - nkeep;
    grant  = keep;
    best   = 0;
    best_p = '0;
    found  = 1'b0;
    // one selection round per free slot; strict compare keeps lower index on ties
    for (int r = 0; r < W; r++) begin
      found  = 1'b0;
      best   = 0;
      best_p = '0;
      for (int m = 0; m < NMOD; m++) begin
        if (req[m] && gate[m] && !grant[m] && (!found || (prio[m] > best_p))) begin
          found  = 1'b1;
          best   = m;
          best_p = prio[m];
        end
      end
      if (found && (r < free)) begin
        for (int m = 0; m < NMOD; m++) begin
          if (m == best) grant[m] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/therm_boost_rest_ctl.sv
module therm_boost_rest_ctl
  import therm_pkg::*;
#(
  parameter int NNODE = 6,
  parameter int NMOD  = 3,
  parameter int W     = 2,
  parameter int TW    = 8,
  parameter int PW    = 4,
  localparam int MW   = $clog2(NMOD + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_vld,
  input  logic [NNODE-1:0][TW-1:0] temp,
  input  logic [NNODE-1:0][TW-1:0] lo_lim,
  input  logic [NNODE-1:0][TW-1:0] hi_lim,
  input  logic [NNODE-1:0][TW-1:0] trig_lvl,
  input  logic [NNODE-1:0][TW-1:0] stop_lvl,
  input  logic [TW-1:0]            hot_lim,
  input  logic [NNODE-1:0]         dont_care,
  input  logic [NNODE-1:0][MW-1:0] node_mod,
  input  logic [NNODE-1:0][PW-1:0] prio_wt,
  output logic [NMOD-1:0]          heat_en,
  output logic                     rest_mode
);
  heat_mode_e              mode_q, mode_d;
  logic [NMOD-1:0]         heat_q, heat_d;
  logic [NNODE-1:0]        nreq, nbelow, nwin, nhot;
  logic                    all_in, rest_now, overheat;
  logic [NMOD-1:0]         mreq, mgate, grant;
  logic [NMOD-1:0][PW-1:0] mprio;

  assign all_in   = &(nwin | dont_care);
  assign rest_now = (mode_q == MODE_REST) || all_in;
  assign overheat = |nhot;

  for (genvar g = 0; g < NNODE; g++) begin : g_node
    therm_node_cell #(.TW(TW)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_vld  (smp_vld),
      .rest_now (rest_now),
      .temp     (temp[g]),
      .lo_lim   (lo_lim[g]),
      .hi_lim   (hi_lim[g]),
      .trig_lvl (trig_lvl[g]),
      .stop_lvl (stop_lvl[g]),
      .hot_lim  (hot_lim),
      .dc       (dont_care[g]),
      .req      (nreq[g]),
      .below_hi (nbelow[g]),
      .in_win   (nwin[g]),
      .over_hot (nhot[g])
    );
  end

  // gather node requests, gate and weight per module
  always_comb begin
    for (int m = 0; m < NMOD; m++) begin
      mreq[m]  = 1'b0;
      mgate[m] = 1'b1;
      mprio[m] = '0;
      for (int i = 0; i < NNODE; i++) begin
        if (node_mod[i] == MW'(m)) begin
          if (nreq[i]) begin
            mreq[m] = 1'b1;
            if (prio_wt[i] > mprio[m]) mprio[m] = prio_wt[i];
          end
          if (rest_now && !nbelow[i]) mgate[m] = 1'b0;
        end
      end
    end
  end

  therm_grant_arb #(.NMOD(NMOD), .W(W), .PW(PW)) u_arb (
    .req   (mreq),
    .gate  (mgate),
    .prio  (mprio),
    .held  (heat_q),
    .grant (grant)
  );

  always_comb begin
    heat_d = overheat ? '0 : grant;
    mode_d = rest_now ? MODE_REST : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      heat_q <= '0;
      mode_q <= MODE_BOOST;
    end else if (smp_vld) begin
      heat_q <= heat_d;
      mode_q <= mode_d;
    end
  end

  assign heat_en   = heat_q;
  assign rest_mode = (mode_q == MODE_REST);
endmodule

// File: rtl/therm_boost_rest_chk.sv
module therm_boost_rest_chk #(
  parameter int NNODE = 6,
  parameter int NMOD  = 3,
  parameter int W     = 2,
  parameter int TW    = 8,
  localparam int MW   = $clog2(NMOD + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     smp_vld,
  input logic [NNODE-1:0][TW-1:0] temp,
  input logic [NNODE-1:0][TW-1:0] hi_lim,
  input logic [TW-1:0]            hot_lim,
  input logic [NNODE-1:0][MW-1:0] node_mod,
  input logic [NMOD-1:0]          heat_en,
  input logic                     rest_mode
);
  logic [NMOD-1:0] hi_blk;
  logic            hot_any;

  always_comb begin
    hot_any = 1'b0;
    for (int i = 0; i < NNODE; i++) if (temp[i] >= hot_lim) hot_any = 1'b1;
    for (int m = 0; m < NMOD; m++) begin
      hi_blk[m] = 1'b0;
      for (int i = 0; i < NNODE; i++)
        if ((node_mod[i] == MW'(m)) && (temp[i] >= hi_lim[i])) hi_blk[m] = 1'b1;
    end
  end

  a_r7_cap: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(heat_en) <= W);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> ($stable(heat_en) && $stable(rest_mode)));

  a_r10_overheat: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && hot_any) |=> (heat_en == '0));

  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rest_mode |=> rest_mode);

  for (genvar m = 0; m < NMOD; m++) begin : g_gate
    a_r6_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_vld && rest_mode && hi_blk[m]) |=> !heat_en[m]);
  end
endmodule

bind therm_boost_rest_ctl therm_boost_rest_chk #(
  .NNODE(NNODE), .NMOD(NMOD), .W(W), .TW(TW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_vld   (smp_vld),
  .temp      (temp),
  .hi_lim    (hi_lim),
  .hot_lim   (hot_lim),
  .node_mod  (node_mod),
  .heat_en   (heat_en),
  .rest_mode (rest_mode)
);

// File: tb/therm_boost_rest_ctl_tb.sv
module therm_boost_rest_ctl_tb;
  localparam int NN = 6;
  localparam int NM = 3;
  localparam int W  = 2;
  localparam int TW = 8;
  localparam int PW = 4;
  localparam int MW = $clog2(NM + 1);

  logic clk, rst_n, smp_vld;
  logic [NN-1:0][TW-1:0] temp, lo_lim, hi_lim, trig_lvl, stop_lvl;
  logic [TW-1:0]         hot_lim;
  logic [NN-1:0]         dont_care;
  logic [NN-1:0][MW-1:0] node_mod;
  logic [NN-1:0][PW-1:0] prio_wt;
  logic [NM-1:0]         heat_en;
  logic                  rest_mode;

  int n_chk = 0;
  int n_fail = 0;
  logic [NM-1:0] exp_heat;
  logic          exp_rest;
  logic [NN-1:0] m_boosted, m_need;

  therm_boost_rest_ctl #(.NNODE(NN), .NMOD(NM), .W(W), .TW(TW), .PW(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .temp(temp), .lo_lim(lo_lim),
    .hi_lim(hi_lim), .trig_lvl(trig_lvl), .stop_lvl(stop_lvl), .hot_lim(hot_lim),
    .dont_care(dont_care), .node_mod(node_mod), .prio_wt(prio_wt),
    .heat_en(heat_en), .rest_mode(rest_mode)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [NM-1:0] eh, input logic er);
    n_chk++;
    if (heat_en !== eh || rest_mode !== er) begin
      n_fail++;
      $display("FAIL %s: heat_en=%b rest_mode=%b expected heat_en=%b rest_mode=%b",
               tag, heat_en, rest_mode, eh, er);
    end
  endtask

  task automatic model_reset();
    exp_heat = '0; exp_rest = 1'b0; m_boosted = '0; m_need = '0;
  endtask

  // expected behaviour of one strobe, written from the requirements
  task automatic model_step();
    logic all_in, eff, ovr;
    logic [NN-1:0] rq;
    logic [NM-1:0] mreq, mgate, g, keep;
    int pr[NM];
    int free, best;
    all_in = 1'b1; ovr = 1'b0;
    for (int i = 0; i < NN; i++) begin
      if (!dont_care[i] && !(temp[i] >= lo_lim[i] && temp[i] <= hi_lim[i])) all_in = 1'b0;
      if (temp[i] >= hot_lim) ovr = 1'b1;
    end
    eff = exp_rest | all_in;
    for (int i = 0; i < NN; i++) begin
      if (eff) rq[i] = dont_care[i] ? 1'b0 : (temp[i] < trig_lvl[i]) ? 1'b1 :
                       (temp[i] >= hi_lim[i]) ? 1'b0 : m_need[i];
      else     rq[i] = !dont_care[i] && !m_boosted[i] && (temp[i] < stop_lvl[i]);
    end
    for (int m = 0; m < NM; m++) begin
      mreq[m] = 1'b0; mgate[m] = 1'b1; pr[m] = 0;
      for (int i = 0; i < NN; i++) if (int'(node_mod[i]) == m) begin
        if (rq[i]) begin
          mreq[m] = 1'b1;
          if (int'(prio_wt[i]) > pr[m]) pr[m] = int'(prio_wt[i]);
        end
        if (eff && temp[i] >= hi_lim[i]) mgate[m] = 1'b0;
      end
    end
    keep = exp_heat & mreq & mgate;
    free = W - $countones(keep);
    g = keep;
    for (int k = 0; k < free; k++) begin
      best = -1;
      for (int m = 0; m < NM; m++)
        if (mreq[m] && mgate[m] && !g[m] && (best < 0 || pr[m] > pr[best])) best = m;
      if (best >= 0) g[best] = 1'b1;
    end
    for (int i = 0; i < NN; i++) begin
      if (!eff && temp[i] >= stop_lvl[i]) m_boosted[i] = 1'b1;
      if (eff) m_need[i] = rq[i];
    end
    exp_heat = ovr ? '0 : g;
    exp_rest = eff;
  endtask

  task automatic strobe(input string tag);
    @(negedge clk);
    smp_vld = 1'b1;
    model_step();
    @(negedge clk);
    smp_vld = 1'b0;
    check(tag, exp_heat, exp_rest);
  endtask

  task automatic set_all(input int v);
    for (int i = 0; i < NN; i++) temp[i] = TW'(v);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; smp_vld = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    check("R1 in reset", '0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", '0, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog R2: run still active expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; smp_vld = 1'b0; hot_lim = TW'(200); dont_care = '0;
    for (int i = 0; i < NN; i++) begin
      lo_lim[i] = TW'(78 + i); trig_lvl[i] = TW'(90 + i);
      hi_lim[i] = TW'(108 + i); stop_lvl[i] = TW'(118 + i);
    end
    // module map: nodes 0,1 -> 0; 2,3 -> 1; 4 -> 2; node 5 unmapped (R11)
    node_mod[0] = 0; node_mod[1] = 0; node_mod[2] = 1;
    node_mod[3] = 1; node_mod[4] = 2; node_mod[5] = 3;
    prio_wt[0] = 1; prio_wt[1] = 2; prio_wt[2] = 5;
    prio_wt[3] = 0; prio_wt[4] = 5; prio_wt[5] = 9;
    set_all(50);
    do_reset();

    // boost: all request; m1,m2 weight 5 beat m0 weight 2; tie keeps both (R8, R11)
    strobe("R3 boost request");
    check("R8 priority pick", 3'b110, 1'b0);
    // higher weight appears on m0 but held grants stay (R9)
    prio_wt[0] = 15;
    strobe("R9 no preempt");
    check("R9 held grants", 3'b110, 1'b0);
    // nodes of m1 reach stop-boost: m1 released, m0 fills the slot
    temp[2] = TW'(125); temp[3] = TW'(125);
    strobe("R3 stop boost");
    check("R3 release", 3'b101, 1'b0);
    temp[2] = TW'(50); temp[3] = TW'(50);
    strobe("R3 no reboost");
    check("R3 no reboost", 3'b101, 1'b0);
    // unmapped node overheats: everything off
    temp[5] = TW'(200);
    strobe("R10 overheat");
    check("R10 all off", 3'b000, 1'b0);
    temp[5] = TW'(50);
    strobe("R10 recover");
    // temperatures change without strobe: outputs hold
    set_all(100);
    repeat (3) @(negedge clk);
    check("R2 idle hold", exp_heat, exp_rest);
    // enter rest with don't-care nodes outside window
    dont_care[4] = 1'b1; dont_care[5] = 1'b1; temp[4] = TW'(50); temp[5] = TW'(30);
    strobe("R4 enter rest");
    check("R4 rest entered", 3'b000, 1'b1);
    temp[0] = TW'(85);
    strobe("R5 trigger");
    check("R5 trigger grant", 3'b001, 1'b1);
    temp[0] = TW'(100);
    strobe("R5 hysteresis");
    check("R5 keep heating", 3'b001, 1'b1);
    temp[0] = TW'(110);
    strobe("R5 high stop");
    check("R5 stopped", 3'b000, 1'b1);
    temp[0] = TW'(85); temp[1] = TW'(112);
    strobe("R6 gate");
    check("R6 gated off", 3'b000, 1'b1);
    temp[1] = TW'(100); temp[2] = TW'(85); dont_care[4] = 1'b0; temp[4] = TW'(85);
    strobe("R7 cap");
    check("R7 two of three", 3'b011, 1'b1);

    // random rest-mode traffic
    for (int n = 0; n < 400; n++) begin
      for (int i = 0; i < NN; i++) begin
        temp[i] = ($urandom_range(0, 59) == 0) ? TW'(205) : TW'(70 + $urandom_range(0, 55));
        if ($urandom_range(0, 15) == 0) dont_care[i] = ~dont_care[i];
        if ($urandom_range(0, 31) == 0) prio_wt[i] = PW'($urandom_range(0, 15));
      end
      repeat ($urandom_range(0, 2)) @(negedge clk);
      strobe("R5/R6/R7/R8/R9/R10 random rest");
    end

    // random boost-mode traffic after a fresh reset
    dont_care = '0;
    do_reset();
    for (int n = 0; n < 300; n++) begin
      for (int i = 0; i < NN; i++)
        temp[i] = TW'(40 + $urandom_range(0, 90));
      if ($urandom_range(0, 7) == 0) node_mod[$urandom_range(0, NN - 1)] = MW'($urandom_range(0, 3));
      strobe("R3/R4/R7/R8/R9/R11 random boost");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule